// File: doc/BRIEF.md
# Iterative BCD-to-Binary Converter

This block turns a six-digit packed BCD number into its 24-bit binary value. It is meant for the receive side of a metering link, where readings arrive as decimal digits but the arithmetic that follows needs plain binary. Each conversion uses a reverse double-dabble loop: one correct-and-shift step per clock, 24 steps in all. The block has no multiplier and no constant table.

A one-cycle `start` pulse captures `bcd_in` while the block is idle. The working BCD register then moves right one bit per clock. The bit leaving its bottom enters a result register at the top, so after 24 steps the result register holds the binary value. Before every shift except the first, each 4-bit digit of 8 or more is first reduced by 3. This keeps the digit weights right after the halving.

At the end of a conversion, `bin_out` and `bad_digit` are updated and `done` pulses for one cycle. Both outputs then hold their values until the next conversion ends. An input nibble above 9 does not stop the run; it only raises `bad_digit`.

Top module: `bcd2bin_iter`

## Requirements
- R1: While reset is asserted, and until the first conversion completes after it, `done`, `bin_out` and `bad_digit` are all 0. Reset is applied asynchronously and released through a two-stage synchronizer.
- R2: A `start` accepted at clock edge E0 makes `done` high for exactly the one cycle that follows edge E24. This is one load edge plus 24 step edges.
- R3: For an input whose six nibbles are all 0 to 9, `bin_out` after `done` equals the decimal number the nibbles spell. Bits [23:20] are the most significant digit and bits [3:0] are the units.
- R4: Before each shift except the first, every working digit of 8 or more has 3 subtracted, with all six digits corrected in parallel. For decimal input, no working digit then ever exceeds 12.
- R5: After the 24th step, the working BCD register is all zeros: the whole input has been moved into the result.
- R6: If any input nibble is above 9, `bad_digit` is 1 after `done`; otherwise it is 0. The conversion still completes, and `bin_out` equals the sum of each nibble times its power of ten.
- R7: A `start` given while a conversion is running is ignored. The running conversion finishes on time with its own result.
- R8: `bin_out` and `bad_digit` change only in the cycle where `done` is high. A change on `bcd_in` or `start` without a completed conversion leaves them unchanged.
- R9: A `start` given in the cycle where `done` is high is accepted and begins the next conversion at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a conversion of `bcd_in` (accepted only when idle) |
| bcd_in | input | 24 | Six packed BCD digits, most significant digit in bits [23:20] |
| done | output | 1 | One-cycle pulse when a result is ready |
| bin_out | output | 24 | Binary value of the last completed conversion |
| bad_digit | output | 1 | Last completed conversion had a nibble above 9 |

## Verification
The bound of 12 on working digits applies only when every loaded nibble is 0 to 9, and the assertion is gated by the captured invalid flag. Invalid inputs therefore never trigger it. The done-timing and hold assertions assume nothing about `start`: it may be held high, pulsed during a run or pulsed in the done cycle, and the bench does all three. The stimulus covers all-zero, all-nine, all-eight and single-digit patterns, pseudo-random decimal values, and nibbles of 10 to 15. The bench model predicts results for every input, valid or not, as the sum of each nibble times its power of ten.

// File: rtl/bcd2bin_pkg.sv
package bcd2bin_pkg;
  localparam int unsigned NIB_W = 4;

  typedef enum logic {
    CV_IDLE = 1'b0,
    CV_RUN  = 1'b1
  } cv_state_e;
endpackage

// File: rtl/bcd2bin_digit_fix.sv
module bcd2bin_digit_fix
  import bcd2bin_pkg::*;
(
  input  logic             en,
  input  logic [NIB_W-1:0] d_in,
  output logic [NIB_W-1:0] d_out
);
  // weight correction: a digit at 8+ carries a half-ten that must become five
  always_comb begin
    if (en && (d_in >= NIB_W'(8))) d_out = d_in - NIB_W'(3);
    else                           d_out = d_in;
  end
endmodule

// File: rtl/bcd2bin_step_ctrl.sv
module bcd2bin_step_ctrl
  import bcd2bin_pkg::*;
#(
  parameter int unsigned STEPS = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic first,
  output logic last,
  output logic done
);
  localparam int unsigned CW = (STEPS > 2) ? $clog2(STEPS) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(STEPS - 1);

  cv_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;

  assign load  = start && (state_q == CV_IDLE);
  assign step  = (state_q == CV_RUN);
  assign first = step && (cnt_q == '0);
  assign last  = step && (cnt_q == LAST_IDX);
  assign done  = done_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    if (load) begin
      state_d = CV_RUN;
      cnt_d   = '0;
    end else if (step) begin
      if (last) begin
        state_d = CV_IDLE;
        done_d  = 1'b1;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CV_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  // R2: the final step is followed by exactly one done cycle
  a_r2_last_then_done: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> done);
  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_IDX);
  // R7: a run in progress keeps stepping whatever start does
  a_r7_run_continues: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !last) |=> step);
endmodule

// File: rtl/bcd2bin_shift_path.sv
module bcd2bin_shift_path
  import bcd2bin_pkg::*;
#(
  parameter int unsigned NDIG = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic                    step,
  input  logic                    first,
  input  logic [NDIG*NIB_W-1:0]   bcd_in,
  output logic [NDIG*NIB_W-1:0]   bcd_q,
  output logic [NDIG*NIB_W-1:0]   res_shift
);
  localparam int unsigned W = NDIG * NIB_W;

  logic [W-1:0] fixed;
  logic [W-1:0] bcd_shift;
  logic [W-1:0] res_q;
  logic [W-1:0] bcd_d, res_d;
  logic         fix_en;

  // the first step sees the loaded digits, which need no correction
  assign fix_en = step && !first;

  for (genvar g = 0; g < NDIG; g++) begin : g_fix
    bcd2bin_digit_fix u_fix (
      .en    (fix_en),
      .d_in  (bcd_q[g*NIB_W +: NIB_W]),
      .d_out (fixed[g*NIB_W +: NIB_W])
    );
  end

  assign bcd_shift = {1'b0, fixed[W-1:1]};
  assign res_shift = {fixed[0], res_q[W-1:1]};

  always_comb begin
    bcd_d = bcd_q;
    res_d = res_q;
    if (load) begin
      bcd_d = bcd_in;
      res_d = '0;
    end else if (step) begin
      bcd_d = bcd_shift;
      res_d = res_shift;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcd_q <= '0;
      res_q <= '0;
    end else begin
      bcd_q <= bcd_d;
      res_q <= res_d;
    end
  end
endmodule

// File: rtl/bcd2bin_iter.sv
module bcd2bin_iter
  import bcd2bin_pkg::*;
#(
  parameter int unsigned NDIG = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [NDIG*NIB_W-1:0] bcd_in,
  output logic                  done,
  output logic [NDIG*NIB_W-1:0] bin_out,
  output logic                  bad_digit
);
  localparam int unsigned W     = NDIG * NIB_W;
  localparam int unsigned STEPS = W;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic         load, step, first, last;
  logic [W-1:0] bcd_q, res_shift;

  bcd2bin_step_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .start (start),
    .load  (load),
    .step  (step),
    .first (first),
    .last  (last),
    .done  (done)
  );

  bcd2bin_shift_path #(.NDIG(NDIG)) u_path (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .load      (load),
    .step      (step),
    .first     (first),
    .bcd_in    (bcd_in),
    .bcd_q     (bcd_q),
    .res_shift (res_shift)
  );

  // nibble range checks on the input and on the working register
  logic [NDIG-1:0] nib_over;
  logic [NDIG-1:0] work_ok;
  for (genvar g = 0; g < NDIG; g++) begin : g_nib
    assign nib_over[g] = bcd_in[g*NIB_W +: NIB_W] > NIB_W'(9);
    assign work_ok[g]  = bcd_q[g*NIB_W +: NIB_W] <= NIB_W'(12);
  end

  logic         bad_q, bad_d;
  logic [W-1:0] bin_q, bin_d;
  logic         flag_q, flag_d;

  always_comb begin
    bad_d  = bad_q;
    bin_d  = bin_q;
    flag_d = flag_q;
    if (load) bad_d = |nib_over;
    if (last) begin
      bin_d  = res_shift;
      flag_d = bad_q;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      bad_q  <= 1'b0;
      bin_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      bad_q  <= bad_d;
      bin_q  <= bin_d;
      flag_q <= flag_d;
    end
  end

  assign bin_out   = bin_q;
  assign bad_digit = flag_q;

  // R4: corrected decimal digits stay within 0..12 between steps
  a_r4_work_digits: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (step && !bad_q) |-> (&work_ok));
  // R5: the working register is drained once the result is out
  a_r5_bcd_drained: assert property (@(posedge clk) disable iff (!rst_sync_q)
    done |-> (bcd_q == '0));
  // R8: published outputs move only with done
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !done |-> ($stable(bin_out) && $stable(bad_digit)));
  // R6: the flag published with done is the one captured at load
  a_r6_flag_from_load: assert property (@(posedge clk) disable iff (!rst_sync_q)
    done |-> (bad_digit == $past(bad_q)));
endmodule

// File: tb/bcd2bin_iter_bench.sv
`timescale 1ns/1ps
module bcd2bin_iter_bench;
  logic        clk;
  logic        rst_n;
  logic        start;
  logic [23:0] bcd_in;
  logic        done;
  logic [23:0] bin_out;
  logic        bad_digit;

  int unsigned n_checks;
  int unsigned n_fail;

  // behavioural reference state
  bit          m_busy;
  int          m_cnt;
  bit          m_done;
  int          m_bin;
  bit          m_bad;
  int          m_exp;
  bit          m_expbad;

  bcd2bin_iter u_bcd2bin_iter (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .bcd_in    (bcd_in),
    .done      (done),
    .bin_out   (bin_out),
    .bad_digit (bad_digit)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int dec_value(input logic [23:0] b);
    int v = 0;
    for (int i = 5; i >= 0; i--) v = v * 10 + int'(b[i*4 +: 4]);
    return v;
  endfunction

  function automatic bit has_bad(input logic [23:0] b);
    bit r = 1'b0;
    for (int i = 0; i < 6; i++) if (b[i*4 +: 4] > 4'd9) r = 1'b1;
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(done == m_done, "R2 done", int'(done), int'(m_done));
    chk(int'(bin_out) == m_bin, m_bad ? "R6 bin_out" : "R3/R8 bin_out", int'(bin_out), m_bin);
    chk(bad_digit == m_bad, "R6/R8 bad_digit", int'(bad_digit), int'(m_bad));
  endtask

  // one clock: drive at negedge, update model for the edge, compare after it
  task automatic tick(input bit s, input logic [23:0] b);
    bit was_busy;
    @(negedge clk);
    start  = s;
    bcd_in = b;
    @(posedge clk);
    #1;
    was_busy = m_busy;
    m_done   = 1'b0;
    if (m_busy) begin
      m_cnt++;
      if (m_cnt == 24) begin
        m_busy = 1'b0;
        m_done = 1'b1;
        m_bin  = m_exp;
        m_bad  = m_expbad;
      end
    end
    if (!was_busy && s) begin   // R7: only an idle block accepts start
      m_busy   = 1'b1;
      m_cnt    = 0;
      m_exp    = dec_value(b);
      m_expbad = has_bad(b);
    end
    compare_all();
  endtask

  task automatic run_to_done();
    int guard = 0;
    while (!m_done && guard < 40) begin
      tick(1'b0, 24'h0);
      guard++;
    end
  endtask

  task automatic convert(input logic [23:0] b);
    tick(1'b1, b);
    run_to_done();
    tick(1'b0, ~b);   // R8: outputs hold while the input changes
  endtask

  initial begin
    int unsigned lfsr;
    logic [23:0] v;
    n_checks = 0;
    n_fail   = 0;
    m_busy = 0; m_cnt = 0; m_done = 0; m_bin = 0; m_bad = 0; m_exp = 0; m_expbad = 0;
    start  = 1'b0;
    bcd_in = 24'h0;
    rst_n  = 1'b0;

    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      chk(done == 1'b0, "R1 done", int'(done), 0);
      chk(bin_out == 24'h0, "R1 bin_out", int'(bin_out), 0);
      chk(bad_digit == 1'b0, "R1 bad_digit", int'(bad_digit), 0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) tick(1'b0, 24'h0);

    // R3: decimal patterns, R5 is covered by its assertion on every run
    convert(24'h000000);
    convert(24'h999999);
    convert(24'h123456);
    convert(24'h000001);
    convert(24'h100000);
    convert(24'h888888);
    convert(24'h000009);
    convert(24'h090909);

    // R6: nibbles above 9 still convert
    convert(24'h00000A);
    convert(24'hFFFFFF);
    convert(24'h90000F);
    convert(24'h5B0C07);

    // R4: pseudo-random decimal values exercise every correction pattern
    lfsr = 32'h1ACE_B00C;
    for (int k = 0; k < 14; k++) begin
      for (int d = 0; d < 6; d++) begin
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 17);
        lfsr = lfsr ^ (lfsr << 5);
        v[d*4 +: 4] = 4'(lfsr % 10);
      end
      convert(v);
    end

    // R7: start pulses while busy are ignored
    tick(1'b1, 24'h314159);
    repeat (3) tick(1'b1, 24'h777777);
    tick(1'b0, 24'h0);
    tick(1'b1, 24'h0000AB);
    run_to_done();
    tick(1'b0, 24'h0);

    // R9: start in the done cycle begins the next conversion
    tick(1'b1, 24'h271828);
    run_to_done();
    tick(1'b1, 24'h161803);
    run_to_done();
    tick(1'b1, 24'h00C001);
    run_to_done();

    // R8: idle cycles with noise on bcd_in keep outputs still
    repeat (6) tick(1'b0, 24'hABCDEF);

    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule